// File: doc/BRIEF.md
# Two-Bit Broadcast Coherence Directory

This block is the home-side directory for a group of memory blocks in a cache-coherent multiprocessor. For each block it keeps only a two-bit state and no record of which caches hold copies. The four states are uncached, shared-clean, exclusive-clean and dirty. Caches send it read misses, write misses and upgrade requests, each tagged with the requester's ID. The directory answers at once when no other cache has to be disturbed.

When the state shows that other copies may exist, the directory cannot name them. It therefore sends one broadcast invalidate that every cache except the requester must acknowledge. The cache that owns a dirty copy returns the block on the same message as its acknowledgement. The completion reply goes out once the last expected acknowledgement has arrived.

Only one broadcast can be in flight at a time. While it is outstanding, any request to that block is refused with a nack, and so is any other request that would need a broadcast of its own. Requests that can be served without a broadcast are still answered.

Top module: `dir2b_ctrl`

## Requirements
- R1: After reset every block is uncached, and every output valid (rsp_valid, inv_valid, cpl_valid, mem_upd_valid) is low until a request or acknowledgement causes it.
- R2: A read (req_op 0) is answered with a data reply (rsp_code 1) one cycle later in these cases. On an uncached block the block becomes exclusive-clean. On an exclusive-clean block it becomes shared-clean. On a shared-clean block it stays shared-clean.
- R3: A write miss (req_op 1), or an upgrade (req_op 2), on an uncached block is answered with a data reply one cycle later, with no invalidate, and the block becomes dirty.
- R4: An upgrade on a block the directory shows as exclusive-clean is answered with a grant (rsp_code 2) one cycle later, with no invalidate, and the block becomes dirty.
- R5: Each of the following issues a broadcast invalidate one cycle later, carrying the block and the requester ID, with no immediate reply: a read of a dirty block, a write miss on a shared-clean, exclusive-clean or dirty block, and an upgrade on a shared-clean or dirty block.
- R6: A broadcast completes after NCACHE-1 acknowledgements from IDs other than the requester. The data completion (cpl_valid) appears one cycle after the last one, carrying the requester and the block. Acknowledgements from the requester, and any received while no broadcast is pending, are ignored.
- R7: During a broadcast for a read, an acknowledgement flagged with data (ack_data) produces a memory update pulse one cycle later, and the block ends shared-clean. A broadcast for a write miss or upgrade ends dirty and causes no memory update.
- R8: While a broadcast is pending, a request to the pending block, or one that would need a broadcast, is nacked (rsp_code 3) one cycle later with no state change. Other requests are served normally.
- R9: Request code 3 is nacked one cycle later and leaves the block state unchanged.
- R10: A completion and an immediate reply triggered in the same cycle are both delivered in the next cycle, each on its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 upgrade, 3 reserved |
| req_id | input | IDW | Requesting cache |
| req_blk | input | BW | Block index |
| ack_valid | input | 1 | Invalidate acknowledgement present |
| ack_id | input | IDW | Acknowledging cache |
| ack_data | input | 1 | Acknowledgement carries the dirty block |
| rsp_valid | output | 1 | Immediate reply valid |
| rsp_code | output | 2 | 1 data, 2 grant, 3 nack |
| rsp_id | output | IDW | Reply destination |
| rsp_blk | output | BW | Reply block |
| inv_valid | output | 1 | Broadcast invalidate pulse |
| inv_blk | output | BW | Block to invalidate |
| inv_src | output | IDW | Requester, which does not acknowledge |
| cpl_valid | output | 1 | Data reply closing a broadcast |
| cpl_id | output | IDW | Requester of the closed broadcast |
| cpl_blk | output | BW | Block of the closed broadcast |
| mem_upd_valid | output | 1 | Write returned dirty data to memory |
| mem_upd_blk | output | BW | Block written to memory |

## Verification
The last counted acknowledgement and a new request can arrive in the same cycle. When that happens, the completion and the request reply both leave in the next cycle, and the request is judged against the pending state as it stood before the completion. The bench provokes this on purpose in three ways: a final acknowledgement alongside a request to another block that needs no broadcast, alongside a request to the pending block itself, and alongside a request that would need a broadcast. Random traffic confined to a few blocks then produces many more such overlaps. A cycle-level bench model predicts every port in every cycle, so both outputs are judged independently.

// File: rtl/dir2b_pkg.sv
package dir2b_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_UP  = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BS_UNC = 2'd0,
        BS_SHR = 2'd1,
        BS_EXC = 2'd2,
        BS_DRT = 2'd3
    } bstate_e;

    typedef enum logic [1:0] {
        RC_NONE  = 2'd0,
        RC_DATA  = 2'd1,
        RC_GRANT = 2'd2,
        RC_NACK  = 2'd3
    } rcode_e;

    // bcast: needs a broadcast; nxt: state after service (after completion if bcast)
    typedef struct packed {
        logic    bcast;
        bstate_e nxt;
        rcode_e  code;
    } decision_t;

    function automatic decision_t decide(op_e op, bstate_e s);
        decision_t d;
        d = '{bcast: 1'b0, nxt: s, code: RC_NACK};
        unique case (op)
            OP_RD: begin
                unique case (s)
                    BS_UNC:  d = '{bcast: 1'b0, nxt: BS_EXC, code: RC_DATA};
                    BS_SHR,
                    BS_EXC:  d = '{bcast: 1'b0, nxt: BS_SHR, code: RC_DATA};
                    default: d = '{bcast: 1'b1, nxt: BS_SHR, code: RC_NONE};
                endcase
            end
            OP_WR, OP_UP: begin
                if (s == BS_UNC)
                    d = '{bcast: 1'b0, nxt: BS_DRT, code: RC_DATA};
                else if (s == BS_EXC && op == OP_UP)
                    d = '{bcast: 1'b0, nxt: BS_DRT, code: RC_GRANT};
                else
                    d = '{bcast: 1'b1, nxt: BS_DRT, code: RC_NONE};
            end
            default: d = '{bcast: 1'b0, nxt: s, code: RC_NACK};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dir_state_store.sv
module dir_state_store
    import dir2b_pkg::*;
#(
    parameter int NBLK = 16,
    parameter int BW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] rd_blk,
    output bstate_e       rd_state,
    input  logic          wa_en,
    input  logic [BW-1:0] wa_blk,
    input  bstate_e       wa_state,
    input  logic          wb_en,
    input  logic [BW-1:0] wb_blk,
    input  bstate_e       wb_state
);

    bstate_e ent [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= BS_UNC;
            else if (wb_en && wb_blk == BW'(g))
                ent[g] <= wb_state;
            else if (wa_en && wa_blk == BW'(g))
                ent[g] <= wa_state;
        end
    end

    assign rd_state = ent[rd_blk];

    // the request path and the completion path never target one entry together
    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wa_en && wb_en && wa_blk == wb_blk)); // R8

endmodule

// File: rtl/dir_bcast_tracker.sv
module dir_bcast_tracker #(
    parameter int NCACHE = 4,
    parameter int IDW    = 2,
    parameter int CW     = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [IDW-1:0] start_id,
    input  logic           ack_valid,
    input  logic [IDW-1:0] ack_id,
    input  logic           ack_data,
    output logic           busy,
    output logic [IDW-1:0] pend_id,
    output logic           fin,
    output logic           data_hit
);

    logic [CW-1:0] cnt;
    logic          counted;

    assign counted  = busy && ack_valid && (ack_id != pend_id) && (int'(ack_id) < NCACHE);
    assign fin      = counted && (cnt == CW'(NCACHE - 2));
    assign data_hit = counted && ack_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            pend_id <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            cnt     <= '0;
            pend_id <= start_id;
        end else if (fin) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (counted) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_ACK_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= CW'(NCACHE - 2))); // R6

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (cnt == '0)); // R6

endmodule

// File: rtl/dir2b_ctrl.sv
module dir2b_ctrl
    import dir2b_pkg::*;
#(
    parameter  int NCACHE = 4,
    parameter  int NBLK   = 16,
    localparam int IDW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int BW     = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int CW     = $clog2(NCACHE + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic [IDW-1:0] req_id,
    input  logic [BW-1:0]  req_blk,
    input  logic           ack_valid,
    input  logic [IDW-1:0] ack_id,
    input  logic           ack_data,
    output logic           rsp_valid,
    output logic [1:0]     rsp_code,
    output logic [IDW-1:0] rsp_id,
    output logic [BW-1:0]  rsp_blk,
    output logic           inv_valid,
    output logic [BW-1:0]  inv_blk,
    output logic [IDW-1:0] inv_src,
    output logic           cpl_valid,
    output logic [IDW-1:0] cpl_id,
    output logic [BW-1:0]  cpl_blk,
    output logic           mem_upd_valid,
    output logic [BW-1:0]  mem_upd_blk
);

    op_e       op_in;
    bstate_e   cur_st;
    decision_t dec;

    logic           busy, fin, data_hit;
    logic [IDW-1:0] pend_id;
    logic [BW-1:0]  pend_blk;
    bstate_e        pend_nxt;
    logic           pend_rd;

    logic conflict, nack, start, imm_wr;

    assign op_in = op_e'(req_op);

    always_comb dec = decide(op_in, cur_st);

    assign conflict = busy && ((req_blk == pend_blk) || dec.bcast);
    assign nack     = req_valid && (conflict || dec.code == RC_NACK);
    assign start    = req_valid && !nack && dec.bcast;
    assign imm_wr   = req_valid && !nack && !dec.bcast;

    dir_state_store #(.NBLK(NBLK), .BW(BW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_blk   (req_blk),
        .rd_state (cur_st),
        .wa_en    (imm_wr),
        .wa_blk   (req_blk),
        .wa_state (dec.nxt),
        .wb_en    (fin),
        .wb_blk   (pend_blk),
        .wb_state (pend_nxt)
    );

    dir_bcast_tracker #(.NCACHE(NCACHE), .IDW(IDW), .CW(CW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_id  (req_id),
        .ack_valid (ack_valid),
        .ack_id    (ack_id),
        .ack_data  (ack_data),
        .busy      (busy),
        .pend_id   (pend_id),
        .fin       (fin),
        .data_hit  (data_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_code      <= RC_NONE;
            rsp_id        <= '0;
            rsp_blk       <= '0;
            inv_valid     <= 1'b0;
            inv_blk       <= '0;
            inv_src       <= '0;
            cpl_valid     <= 1'b0;
            cpl_id        <= '0;
            cpl_blk       <= '0;
            mem_upd_valid <= 1'b0;
            mem_upd_blk   <= '0;
            pend_blk      <= '0;
            pend_nxt      <= BS_UNC;
            pend_rd       <= 1'b0;
        end else begin
            rsp_valid     <= req_valid && !start;
            rsp_code      <= nack ? RC_NACK : dec.code;
            rsp_id        <= req_id;
            rsp_blk       <= req_blk;
            inv_valid     <= start;
            inv_blk       <= req_blk;
            inv_src       <= req_id;
            cpl_valid     <= fin;
            cpl_id        <= pend_id;
            cpl_blk       <= pend_blk;
            mem_upd_valid <= data_hit && pend_rd;
            mem_upd_blk   <= pend_blk;
            if (start) begin
                pend_blk <= req_blk;
                pend_nxt <= dec.nxt;
                pend_rd  <= (op_in == OP_RD);
            end
        end
    end

    AST_NACK_PENDING: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy && req_blk == pend_blk)
        |=> (rsp_valid && rsp_code == RC_NACK)); // R8

    AST_UPGRADE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && op_in == OP_UP && cur_st == BS_EXC)
        |=> (!inv_valid && rsp_valid && rsp_code == RC_GRANT)); // R4

    AST_INV_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> busy); // R5

    AST_MEM_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        mem_upd_valid |-> $past(ack_valid && ack_data)); // R7

    AST_RSV_NACK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_in == OP_RSV) |=> (rsp_valid && rsp_code == RC_NACK)); // R9

endmodule

// File: tb/tb_dir2b_ctrl.sv
module tb_dir2b_ctrl;

    localparam int NC = 4;
    localparam int NB = 16;
    localparam int IW = 2;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [IW-1:0] req_id = '0;
    logic [BW-1:0] req_blk = '0;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_id = '0;
    logic          ack_data = 1'b0;
    logic          rsp_valid, inv_valid, cpl_valid, mem_upd_valid;
    logic [1:0]    rsp_code;
    logic [IW-1:0] rsp_id, inv_src, cpl_id;
    logic [BW-1:0] rsp_blk, inv_blk, cpl_blk, mem_upd_blk;

    always #2 clk = ~clk;

    dir2b_ctrl #(.NCACHE(NC), .NBLK(NB)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_id(req_id), .req_blk(req_blk),
        .ack_valid(ack_valid), .ack_id(ack_id), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_id(rsp_id), .rsp_blk(rsp_blk),
        .inv_valid(inv_valid), .inv_blk(inv_blk), .inv_src(inv_src),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_blk(cpl_blk),
        .mem_upd_valid(mem_upd_valid), .mem_upd_blk(mem_upd_blk)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model: 0 uncached, 1 shared, 2 exclusive, 3 dirty
    int ms [NB];
    bit mbusy = 0;
    int mcnt = 0;
    int mpid = 0;
    int mpblk = 0;
    int mpnxt = 0;
    bit mprd = 0;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // expected outcome of one request for a given op and state
    task automatic predict(int op, int s, output bit bc, output int nxt, output int code,
                           output string tag);
        bc = 0; nxt = s; code = 3; tag = "R9";
        if (op == 0) begin
            if (s == 3) begin bc = 1; nxt = 1; code = 0; tag = "R5"; end
            else begin code = 1; nxt = (s == 0) ? 2 : 1; tag = "R2"; end
        end else if (op == 1 || op == 2) begin
            if (s == 0) begin code = 1; nxt = 3; tag = "R3"; end
            else if (s == 2 && op == 2) begin code = 2; nxt = 3; tag = "R4"; end
            else begin bc = 1; nxt = 3; code = 0; tag = "R5"; end
        end
    endtask

    // drive one cycle of stimulus at a negedge and check every port at the next negedge
    task automatic cycle(bit rv, int op, int id, int blk, bit av, int aid, bit ad);
        bit    e_rsp = 0, e_inv = 0, e_cpl = 0, e_mem = 0, fin = 0;
        int    e_code = 0, e_cid = 0, e_cblk = 0, e_mblk = 0, fin_blk = 0, fin_st = 0;
        bit    bc;
        int    nxt, code;
        string tag = "R2";
        req_valid = rv; req_op = 2'(op); req_id = IW'(id); req_blk = BW'(blk);
        ack_valid = av; ack_id = IW'(aid); ack_data = ad;
        if (mbusy && av && aid != mpid) begin
            if (ad && mprd) begin e_mem = 1; e_mblk = mpblk; end
            if (mcnt == NC - 2) begin
                fin = 1; e_cpl = 1; e_cid = mpid; e_cblk = mpblk;
                fin_blk = mpblk; fin_st = mpnxt;
            end else mcnt++;
        end
        if (rv) begin
            predict(op, ms[blk], bc, nxt, code, tag);
            e_rsp = 1;
            if (op == 3) e_code = 3;
            else if (mbusy && (blk == mpblk || bc)) begin e_code = 3; tag = "R8"; end
            else if (bc) begin
                e_rsp = 0; e_inv = 1;
                mpid = id; mpblk = blk; mpnxt = nxt; mprd = (op == 0); mcnt = 0;
            end else begin
                e_code = code; ms[blk] = nxt;
            end
            if (e_rsp && e_cpl) tag = "R10";
        end
        if (fin) begin ms[fin_blk] = fin_st; mbusy = 0; end
        if (e_inv) mbusy = 1;
        @(negedge clk);
        chk(tag, "rsp_valid", int'(rsp_valid), int'(e_rsp));
        if (e_rsp) begin
            chk(tag, "rsp_code", int'(rsp_code), e_code);
            chk(tag, "rsp_id", int'(rsp_id), id);
            chk(tag, "rsp_blk", int'(rsp_blk), blk);
        end
        chk("R5", "inv_valid", int'(inv_valid), int'(e_inv));
        if (e_inv) begin
            chk("R5", "inv_blk", int'(inv_blk), blk);
            chk("R5", "inv_src", int'(inv_src), id);
        end
        chk("R6", "cpl_valid", int'(cpl_valid), int'(e_cpl));
        if (e_cpl) begin
            chk("R6", "cpl_id", int'(cpl_id), e_cid);
            chk("R6", "cpl_blk", int'(cpl_blk), e_cblk);
        end
        chk("R7", "mem_upd_valid", int'(mem_upd_valid), int'(e_mem));
        if (e_mem) chk("R7", "mem_upd_blk", int'(mem_upd_blk), e_mblk);
        req_valid = 0; ack_valid = 0; ack_data = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < NB; i++) ms[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "inv_valid", int'(inv_valid), 0);
        chk("R1", "cpl_valid", int'(cpl_valid), 0);
        chk("R1", "mem_upd_valid", int'(mem_upd_valid), 0);
        // R1/R2: reads walk uncached -> exclusive -> shared
        cycle(1, 0, 1, 0, 0, 0, 0);
        cycle(1, 0, 2, 0, 0, 0, 0);
        cycle(1, 0, 3, 0, 0, 0, 0);
        // R4: exclusive upgrade is granted quietly
        cycle(1, 0, 0, 1, 0, 0, 0);
        cycle(1, 2, 0, 1, 0, 0, 0);
        // R3: write miss on uncached
        cycle(1, 1, 1, 2, 0, 0, 0);
        // R6: idle acknowledgement ignored
        cycle(0, 0, 0, 0, 1, 2, 1);
        // R5/R7: read of dirty block 2 from cache 0
        cycle(1, 0, 0, 2, 0, 0, 0);
        cycle(1, 0, 1, 2, 1, 0, 0);   // R8 nack same block, requester ack ignored (R6)
        cycle(1, 1, 2, 0, 1, 1, 1);   // R8 broadcast-needing nacked; owner data ack (R7)
        cycle(1, 0, 3, 3, 1, 2, 0);   // other block served during pending
        cycle(1, 0, 2, 4, 1, 3, 0);   // R10 final ack with immediate reply
        // R9: reserved code
        cycle(1, 3, 1, 4, 0, 0, 0);
        // R10/R8: write broadcast, final ack beside requests to the pending block
        cycle(1, 1, 3, 4, 0, 0, 0);
        cycle(0, 0, 0, 0, 1, 0, 0);
        cycle(0, 0, 0, 0, 1, 1, 0);
        cycle(1, 0, 0, 4, 1, 2, 0);
        // R10/R8: final ack beside a request that needs a new broadcast
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 1, 1, 0);
        cycle(0, 0, 0, 0, 1, 2, 0);
        cycle(1, 1, 1, 2, 1, 3, 0);
        // constrained random traffic on a few blocks
        for (int n = 0; n < 4000; n++) begin
            bit rv = ($urandom % 2) == 0;
            int op = ($urandom % 10 == 0) ? 3 : int'($urandom % 3);
            int id = int'($urandom % NC);
            int blk = int'($urandom % 4);
            bit av = mbusy ? (($urandom % 2) == 0) : (($urandom % 8) == 0);
            int aid = int'($urandom % NC);
            bit ad = ($urandom % 4) == 0;
            cycle(rv, op, id, blk, av, aid, ad);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule